// File: doc/BRIEF.md
# Masked Host-to-Internal Address Remap Window

This block sits between a host-side firmware/memory cycle decoder and an internal bus master. It holds one programmable window. The window is defined by two 32-bit configuration words written over a simple register port. During every host address phase the block checks whether the 32-bit host address lies in the window. It builds the internal-bus address and flags either a hit or a miss. The low 16 address bits always pass straight through. Only the upper 16 bits are steered by two masks:

- a replace mask, whose set bits are taken from the internal target base;
- a keep mask, whose set bits are copied from the host address.

Translation is pure bitwise select-and-merge. It contains no adder. A target base that is not aligned to the window size therefore fragments the window rather than shifting it.

Configuration writes land in staging copies, and those copies are what reads return. A small two-state controller moves the staged words into the active copy only on an edge where no host address phase is in progress. The controller's states are:

- `CFG_SYNCED`: the active copy equals the staged one.
- `CFG_PENDING`: a write is waiting to be applied.

Its transitions are:

- SYNCED→PENDING on any write.
- PENDING→PENDING while the host is mid-phase or another write arrives.
- PENDING→SYNCED, with the commit, on an edge where the host is idle and no write arrives.
- SYNCED→SYNCED otherwise.

A parameter `REG_OUT` adds one register stage on the hit, miss and address outputs.

Top module: `lpc_remap_window`

## Requirements
- R1: After reset both configuration words read back as zero, the controller is in `CFG_SYNCED`, and every host phase reports a miss.
- R2: A write stores `cfg_wdata` into the word chosen by `cfg_sel` (0 = map word, 1 = mask word), and `cfg_rdata` returns the staged word for the current `cfg_sel` from the cycle after the write.
- R3: With the window enabled, a host phase hits when `(host_addr[31:16] ^ map[15:0]) & mask[31:16]` is zero; map[15:0] is the host base, mask[31:16] the replace mask.
- R4: `bus_addr[31:16]` = `(map[31:16] & mask[31:16]) | (host_addr[31:16] & mask[15:0])`; map[31:16] is the target base and mask[15:0] the keep mask.
- R5: `bus_addr[15:0]` always equals `host_addr[15:0]`.
- R6: `win_hit` and `win_miss` are never both high, both are low when `host_phase` is low, and a host phase that does not hit reports a miss.
- R7: While the active mask word is zero the window is disabled and no host phase hits.
- R8: A staged write becomes active only at a clock edge where `host_phase` is low; with the host idle it is active after the second edge following the write.
- R9: An unaligned target base is merged bitwise with no carry between mask fields; for example, target 0x4003 with replace 0xFFF0 and keep 0x000F maps host bits 0xC to 0x400C.
- R10: With `REG_OUT`=1, `win_hit`, `win_miss` and `bus_addr` equal the `REG_OUT`=0 values one clock later, and are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Word select: 0 map word, 1 mask word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Staged word selected by cfg_sel |
| host_phase | input | 1 | High during a host address phase |
| host_addr | input | 32 | Host firmware-space address |
| win_hit | output | 1 | Address falls in the window |
| win_miss | output | 1 | Host phase outside the window |
| bus_addr | output | 32 | Translated internal-bus address |

## Verification
The hardest situation to reach is a configuration write that arrives while a host address phase is held across several cycles. In that case the staged and active words must differ for a while, and the commit must land exactly on the first idle edge. The stimulus writes the mask word in the middle of a long host phase. It keeps that phase up while checking that lookups still use the old configuration, then drops the phase for a single cycle. A randomised stretch also issues back-to-back writes on the commit edge itself. The fragmentation case is reached by programming an unaligned target base and probing host addresses whose keep bits would carry under an adder.

// File: rtl/lpc_remap_pkg.sv
package lpc_remap_pkg;
    typedef enum logic {
        CFG_SYNCED  = 1'b0,
        CFG_PENDING = 1'b1
    } cfg_state_e;

    localparam logic SEL_MAP = 1'b0;
    localparam logic SEL_CTL = 1'b1;
endpackage

// File: rtl/lpc_remap_regs.sv
module lpc_remap_regs
    import lpc_remap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              host_phase,
    output logic [ADDR_W-1:0] act_map,
    output logic [ADDR_W-1:0] act_ctl
);
    cfg_state_e        state_q, state_d;
    logic              commit;
    logic [ADDR_W-1:0] stg_map, stg_ctl;

    // staging copies, written directly by the register port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_map <= '0;
            stg_ctl <= '0;
        end else if (cfg_wr) begin
            if (cfg_sel == SEL_CTL) stg_ctl <= cfg_wdata;
            else                    stg_map <= cfg_wdata;
        end
    end

    assign cfg_rdata = (cfg_sel == SEL_CTL) ? stg_ctl : stg_map;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_SYNCED;
        else        state_q <= state_d;
    end

    // next state and commit strobe
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            CFG_SYNCED: begin
                if (cfg_wr) state_d = CFG_PENDING;
            end
            CFG_PENDING: begin
                commit = !host_phase;
                if (!cfg_wr && !host_phase) state_d = CFG_SYNCED;
            end
        endcase
    end

    // active copy, only touched between host address phases
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_map <= '0;
            act_ctl <= '0;
        end else if (commit) begin
            act_map <= stg_map;
            act_ctl <= stg_ctl;
        end
    end
endmodule

// File: rtl/lpc_remap_match.sv
module lpc_remap_match #(
    parameter int ADDR_W = 32,
    localparam int HALF = ADDR_W / 2
) (
    input  logic            host_phase,
    input  logic [HALF-1:0] host_hi,
    input  logic [HALF-1:0] base_hi,
    input  logic [HALF-1:0] repl_mask,
    input  logic            win_en,
    output logic            hit,
    output logic            miss
);
    logic [HALF-1:0] diff;
    logic            in_range;

    assign diff     = (host_hi ^ base_hi) & repl_mask;
    assign in_range = (diff == '0);
    assign hit      = host_phase && win_en && in_range;
    assign miss     = host_phase && !(win_en && in_range);
endmodule

// File: rtl/lpc_remap_compose.sv
module lpc_remap_compose #(
    parameter int ADDR_W = 32,
    localparam int HALF = ADDR_W / 2
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [HALF-1:0]   tgt_hi,
    input  logic [HALF-1:0]   repl_mask,
    input  logic [HALF-1:0]   keep_mask,
    output logic [ADDR_W-1:0] out_addr
);
    genvar b;
    generate
        for (b = 0; b < HALF; b++) begin : g_hi
            assign out_addr[HALF+b] = (tgt_hi[b] & repl_mask[b]) |
                                      (host_addr[HALF+b] & keep_mask[b]);
        end
    endgenerate

    assign out_addr[HALF-1:0] = host_addr[HALF-1:0];
endmodule

// File: rtl/lpc_remap_outstage.sv
module lpc_remap_outstage #(
    parameter int ADDR_W  = 32,
    parameter bit REG_OUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_in,
    input  logic              miss_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              hit_out,
    output logic              miss_out,
    output logic [ADDR_W-1:0] addr_out
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hit_out  <= 1'b0;
                    miss_out <= 1'b0;
                    addr_out <= '0;
                end else begin
                    hit_out  <= hit_in;
                    miss_out <= miss_in;
                    addr_out <= addr_in;
                end
            end
        end else begin : g_comb
            assign hit_out  = hit_in;
            assign miss_out = miss_in;
            assign addr_out = addr_in;
        end
    endgenerate
endmodule

// File: rtl/lpc_remap_window.sv
module lpc_remap_window #(
    parameter int ADDR_W  = 32,
    parameter bit REG_OUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              host_phase,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              win_hit,
    output logic              win_miss,
    output logic [ADDR_W-1:0] bus_addr
);
    localparam int HALF = ADDR_W / 2;

    logic [ADDR_W-1:0] act_map, act_ctl;
    logic              raw_hit, raw_miss;
    logic [ADDR_W-1:0] raw_addr;
    logic              win_en;

    lpc_remap_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .host_phase(host_phase), .act_map(act_map), .act_ctl(act_ctl)
    );

    assign win_en = (act_ctl != '0);

    lpc_remap_match #(.ADDR_W(ADDR_W)) u_match (
        .host_phase(host_phase), .host_hi(host_addr[ADDR_W-1:HALF]),
        .base_hi(act_map[HALF-1:0]), .repl_mask(act_ctl[ADDR_W-1:HALF]),
        .win_en(win_en), .hit(raw_hit), .miss(raw_miss)
    );

    lpc_remap_compose #(.ADDR_W(ADDR_W)) u_compose (
        .host_addr(host_addr), .tgt_hi(act_map[ADDR_W-1:HALF]),
        .repl_mask(act_ctl[ADDR_W-1:HALF]), .keep_mask(act_ctl[HALF-1:0]),
        .out_addr(raw_addr)
    );

    lpc_remap_outstage #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_out (
        .clk(clk), .rst_n(rst_n), .hit_in(raw_hit), .miss_in(raw_miss),
        .addr_in(raw_addr), .hit_out(win_hit), .miss_out(win_miss),
        .addr_out(bus_addr)
    );
endmodule

// File: rtl/lpc_remap_chk.sv
module lpc_remap_chk #(
    parameter int ADDR_W  = 32,
    parameter bit REG_OUT = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              cfg_sel,
    input logic [ADDR_W-1:0] cfg_wdata,
    input logic [ADDR_W-1:0] cfg_rdata,
    input logic              host_phase,
    input logic [ADDR_W-1:0] host_addr,
    input logic              win_hit,
    input logic              win_miss,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [ADDR_W-1:0] act_map,
    input logic [ADDR_W-1:0] act_ctl
);
    localparam int HALF = ADDR_W / 2;

    // R6
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_hit && win_miss));

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_sel != $past(cfg_sel)) || (cfg_rdata == $past(cfg_wdata)));

    // R8
    commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_phase) |-> ($stable(act_map) && $stable(act_ctl)));

    generate
        if (!REG_OUT) begin : g_comb_chk
            // R6
            idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !host_phase |-> (!win_hit && !win_miss));
            // R5
            low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
                bus_addr[HALF-1:0] == host_addr[HALF-1:0]);
            // R7
            disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (act_ctl == '0) |-> !win_hit);
        end
    endgenerate
endmodule

bind lpc_remap_window lpc_remap_chk #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .host_phase(host_phase),
    .host_addr(host_addr), .win_hit(win_hit), .win_miss(win_miss),
    .bus_addr(bus_addr), .act_map(act_map), .act_ctl(act_ctl)
);

// File: tb/sim_lpc_remap_window.sv
`timescale 1ns/1ps
module sim_lpc_remap_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        host_phase = 1'b0;
    logic [31:0] host_addr = '0;
    logic [31:0] rdata0, rdata1, addr0, addr1;
    logic        hit0, miss0, hit1, miss1;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    lpc_remap_window u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata0), .host_phase(host_phase),
        .host_addr(host_addr), .win_hit(hit0), .win_miss(miss0), .bus_addr(addr0)
    );

    lpc_remap_window #(.REG_OUT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata1), .host_phase(host_phase),
        .host_addr(host_addr), .win_hit(hit1), .win_miss(miss1), .bus_addr(addr1)
    );

    // reference model state
    logic [31:0] m_stg_map = '0, m_stg_ctl = '0, m_act_map = '0, m_act_ctl = '0;
    bit          m_pend = 0;
    logic        p_hit = 0, p_miss = 0;
    logic [31:0] p_addr = '0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    // one clock: drive, compare comb outputs, advance model on the edge
    task automatic cyc(input bit hp, input logic [31:0] a, input bit wr,
                       input bit sel, input logic [31:0] wd, input string tag);
        logic [15:0] repl, keep, hi;
        logic        e_hit, e_miss;
        logic [31:0] e_addr, e_rd;
        host_phase = hp; host_addr = a; cfg_wr = wr; cfg_sel = sel; cfg_wdata = wd;
        #1;
        repl   = m_act_ctl[31:16];
        keep   = m_act_ctl[15:0];
        hi     = (m_act_map[31:16] & repl) | (a[31:16] & keep);
        e_hit  = hp && (m_act_ctl != 0) && (((a[31:16] ^ m_act_map[15:0]) & repl) == 0);
        e_miss = hp && !e_hit;
        e_addr = {hi, a[15:0]};
        e_rd   = sel ? m_stg_ctl : m_stg_map;
        check({hit0, miss0} == {e_hit, e_miss}, {tag, " hit/miss"},
              {62'd0, hit0, miss0}, {62'd0, e_hit, e_miss});
        check(addr0 == e_addr, {tag, " bus_addr"}, {32'd0, addr0}, {32'd0, e_addr});
        check(rdata0 == e_rd, "R2 readback", {32'd0, rdata0}, {32'd0, e_rd});
        check({hit1, miss1, addr1} == {p_hit, p_miss, p_addr}, "R10 registered",
              {30'd0, hit1, miss1, addr1}, {30'd0, p_hit, p_miss, p_addr});
        @(posedge clk);
        if (m_pend && !hp) begin
            m_act_map = m_stg_map;
            m_act_ctl = m_stg_ctl;
        end
        if (wr) begin
            if (sel) m_stg_ctl = wd; else m_stg_map = wd;
            m_pend = 1;
        end else if (!hp) begin
            m_pend = 0;
        end
        p_hit = e_hit; p_miss = e_miss; p_addr = e_addr;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state: zero words, every phase misses
        cyc(0, 32'h0, 0, 0, 0, "R1");
        cyc(0, 32'h0, 0, 1, 0, "R1");
        cyc(1, 32'h1234_5678, 0, 0, 0, "R1");
        cyc(1, 32'h0000_0000, 0, 1, 0, "R1");
        // R2 map word write; R7 window still disabled
        cyc(0, 32'h0, 1, 0, 32'h4000_0E00, "R2");
        cyc(0, 32'h0, 0, 0, 0, "R2");
        cyc(1, 32'h0E00_1234, 0, 0, 0, "R7");
        cyc(0, 32'h0, 0, 0, 0, "R7");
        // R8 mask write in mid phase: old config holds until idle edge
        cyc(1, 32'h0E05_ABCD, 1, 1, 32'hFFF0_000F, "R8");
        for (int i = 0; i < 4; i++) cyc(1, 32'h0E05_ABCD, 0, 1, 0, "R8");
        cyc(0, 32'h0E05_ABCD, 0, 1, 0, "R8");
        // R3 R4 R5 hit with composed address
        cyc(1, 32'h0E05_ABCD, 0, 0, 0, "R3");
        cyc(1, 32'h0E0F_FFFF, 0, 0, 0, "R4");
        cyc(1, 32'h0E00_0001, 0, 0, 0, "R5");
        // R6 outside the window
        cyc(1, 32'h0F00_0000, 0, 0, 0, "R6");
        cyc(1, 32'h0E10_0000, 0, 0, 0, "R6");
        cyc(0, 32'h0E05_0000, 0, 0, 0, "R6");
        // R9 unaligned target base: bitwise merge, no carry
        cyc(0, 32'h0, 1, 0, 32'h4003_0E00, "R9");
        cyc(0, 32'h0, 0, 0, 0, "R9");
        cyc(1, 32'h0E0C_0000, 0, 0, 0, "R9");
        cyc(1, 32'h0E05_0011, 0, 0, 0, "R9");
        // R3 other mask shape; base bits outside replace mask are ignored
        cyc(0, 32'h0, 1, 1, 32'hFF00_00FF, "R3");
        cyc(0, 32'h0, 1, 0, 32'h9A5C_0E77, "R3");
        cyc(0, 32'h0, 0, 0, 0, "R3");
        cyc(1, 32'h0E33_0042, 0, 0, 0, "R3");
        cyc(1, 32'h0D33_0042, 0, 0, 0, "R3");
        // R8 randomised phases and writes, including writes on commit edges
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, wd;
            bit hp, wr, sel;
            a   = {4'h0, $urandom_range(0, 15) > 7 ? 4'hE : 4'hD, 8'($urandom), 16'($urandom)};
            hp  = ($urandom_range(0, 3) != 0);
            wr  = ($urandom_range(0, 9) == 0);
            sel = 1'($urandom);
            wd  = sel ? {8'hFF, 8'($urandom), 8'($urandom), 8'h0F} : 32'($urandom);
            cyc(hp, a, wr, sel, wd, "R8");
        end
        // R7 disable again with a zero mask word
        cyc(0, 32'h0, 1, 1, 32'h0, "R7");
        cyc(0, 32'h0, 0, 1, 0, "R7");
        cyc(1, 32'h0E00_0000, 0, 0, 0, "R7");
        cyc(1, 32'h0000_0000, 0, 0, 0, "R7");
        cyc(0, 32'h0, 0, 0, 0, "R10");
        finish_run();
    end
endmodule